// File: doc/BRIEF.md
# Floating-Point Control and Exception Status Register

This block holds the control and status state that an arithmetic unit's floating-point datapath needs around each operation. A 2-bit rounding-mode field, written by software, is decoded into a one-hot select for the downstream units. Five exception kinds are tracked: inexact, divide-by-zero, invalid, overflow and underflow. Each kind has a sticky status bit and a trap-enable bit.

The datapath pulses `op_start` when an operation begins. This empties a per-operation accumulator of raw exception indications. While the operation runs, raw indications are OR-ed into that accumulator. On `op_end` the accumulated set is merged into the sticky bits. A flag that changes from clear to set with its enable on appears in a one-cycle trap pulse that carries a cause mask. A flag whose sticky bit is already set never traps again, so software sees one trap per newly raised condition. Software reads and writes the whole state through a single 12-bit register word. A write takes effect at the next clock edge and overrides any merge on that edge.

Top module: `fpsr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears all sticky and enable bits, sets the rounding mode to 0, and drives no trap: `sw_rd_data` = 0, `rnd_onehot` = 4'b0001, `trap_pulse` = 0.
- R2: Rounding mode m (0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity) drives exactly one bit of `rnd_onehot`, bit m.
- R3: On a cycle with `op_start` high, raw flags seen in earlier cycles are discarded. Only flags raised in the `op_start` cycle or later reach the merge at `op_end`.
- R4: An `op_end` whose accumulated raw set is empty leaves the sticky bits unchanged and raises no trap.
- R5: At `op_end`, every accumulated raw flag sets its sticky bit. Sticky bits stay set until reset or a software write.
- R6: The edge that takes `op_end` sets `trap_pulse` high for exactly one cycle. It does so when at least one flag changes from clear to set with its enable bit 1, and `trap_cause` then holds exactly those flags. Otherwise `trap_pulse` is 0 and `trap_cause` is 0.
- R7: A raw flag whose sticky bit is already 1 adds nothing to `trap_cause` and raises no trap.
- R8: A newly set flag whose enable bit is 0 sets its sticky bit but raises no trap.
- R9: When `sw_wr_en` and `op_end` are high in the same cycle, the written word replaces the state and no trap is raised.
- R10: The register word layout is: bits [1:0] rounding mode, bits [6:2] sticky flags, bits [11:7] enables. Within each 5-bit field, bit 0 is inexact, bit 1 divide-by-zero, bit 2 invalid, bit 3 overflow and bit 4 underflow. A write is visible on `sw_rd_data` after the next clock edge.
- R11: Raw flags raised on several cycles between `op_start` and `op_end` are OR-combined before the merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Operation begins; empties the raw-flag accumulator |
| op_end | input | 1 | Operation completes; merges flags into status |
| raw_flags | input | 5 | Raw exception indications from the datapath |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_data | input | 12 | Software write word |
| sw_rd_data | output | 12 | Current register word |
| rnd_onehot | output | 4 | One-hot decoded rounding mode |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_cause | output | 5 | Flags that newly triggered the trap |

## Verification
Every piece of state is visible on `sw_rd_data` one edge after it changes. A wrong sticky bit, enable bit or rounding mode therefore shows up at the first compare after the cycle that corrupted it. A corrupted accumulator is hidden until the next `op_end`. It then shows as an extra or missing sticky bit, together with a spurious or missing trap, in the cycle right after that edge. The vectors are ordered so that stale flags sit in the accumulator across an `op_start` before an empty `op_end`, which exposes that hidden state.

// File: rtl/fpsr_pkg.sv
// Package: shared widths, rounding-mode encoding and flag bit positions
// for the floating-point control/status register.
package fpsr_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int RM_W      = 2;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST_EVEN = 2'd0,
        RM_TOWARD_ZERO  = 2'd1,
        RM_TOWARD_NEG   = 2'd2,
        RM_TOWARD_POS   = 2'd3
    } rnd_mode_e;

    // Bit position of each exception kind inside every flag field.
    localparam int FLG_INEXACT  = 0;
    localparam int FLG_DIVZERO  = 1;
    localparam int FLG_INVALID  = 2;
    localparam int FLG_OVERFLOW = 3;
    localparam int FLG_UNDERFL  = 4;
endpackage

// File: rtl/fpsr_rnd_decode.sv
// Module: fpsr_rnd_decode
// Turns the binary rounding-mode field into a one-hot select.
// Assumes: purely combinational; every code of the field is a valid mode.
module fpsr_rnd_decode #(
    parameter int RM_W = 2,
    localparam int NUM_MODES = 1 << RM_W
) (
    input  logic [RM_W-1:0]      mode,
    output logic [NUM_MODES-1:0] onehot
);
    // One compare per mode code drives that mode's select bit.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        assign onehot[m] = (mode == RM_W'(m));
    end
endmodule

// File: rtl/fpsr_flag_acc.sv
// Module: fpsr_flag_acc
// Per-operation raw exception accumulator. It is emptied at op start,
// OR-collects raw flags while the operation runs, and presents the
// combined set to the merge logic.
// Assumes: flags raised in the op_start cycle belong to the new operation;
// the accumulator also empties at op_end so that no set is merged twice.
module fpsr_flag_acc #(
    parameter int NUM_FLAGS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_end,
    input  logic [NUM_FLAGS-1:0] raw_flags,
    output logic [NUM_FLAGS-1:0] pending
);
    logic [NUM_FLAGS-1:0] acc_q;

    // Combined set seen so far by the current operation, this cycle included.
    always_comb begin
        pending = (op_start ? '0 : acc_q) | raw_flags;
    end

    // Hold the running set; empty it on reset or when the operation ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (op_end) begin
            acc_q <= '0;
        end else begin
            acc_q <= pending;
        end
    end
endmodule

// File: rtl/fpsr_sticky_merge.sv
// Module: fpsr_sticky_merge
// Holds the sticky status bits and trap enables. On op_end it merges the
// pending flag set and raises a one-cycle trap for flags that change from
// clear to set with their enable on.
// Assumes: a software write in the same cycle overrides the merge and
// suppresses the trap.
module fpsr_sticky_merge #(
    parameter int NUM_FLAGS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_end,
    input  logic [NUM_FLAGS-1:0] pending,
    input  logic                 sw_wr_en,
    input  logic [NUM_FLAGS-1:0] sw_sticky,
    input  logic [NUM_FLAGS-1:0] sw_enable,
    output logic [NUM_FLAGS-1:0] sticky,
    output logic [NUM_FLAGS-1:0] enable,
    output logic                 trap_pulse,
    output logic [NUM_FLAGS-1:0] trap_cause
);
    logic [NUM_FLAGS-1:0] newly_set;
    logic [NUM_FLAGS-1:0] cause_next;

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        // A flag is new only if raised at op end while its sticky bit is clear.
        assign newly_set[f]  = op_end & pending[f] & ~sticky[f];
        assign cause_next[f] = newly_set[f] & enable[f] & ~sw_wr_en;

        // Sticky bit: reset clears it, a write loads it, a merge sets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sticky[f] <= 1'b0;
            end else if (sw_wr_en) begin
                sticky[f] <= sw_sticky[f];
            end else if (newly_set[f]) begin
                sticky[f] <= 1'b1;
            end
        end

        // Enable bit: changes only through reset or a software write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enable[f] <= 1'b0;
            end else if (sw_wr_en) begin
                enable[f] <= sw_enable[f];
            end
        end
    end

    // Register the trap request and its cause mask for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse <= 1'b0;
            trap_cause <= '0;
        end else begin
            trap_pulse <= |cause_next;
            trap_cause <= cause_next;
        end
    end
endmodule

// File: rtl/fpsr_ctrl.sv
// Module: fpsr_ctrl (top)
// Floating-point control/status register: rounding mode, sticky exception
// flags and trap enables, all packed in one software-visible word.
// Layout: [RM_W-1:0] mode, then NUM_FLAGS sticky bits, then NUM_FLAGS enables.
// Assumes: synchronous active-low reset; software writes win over op_end.
module fpsr_ctrl #(
    parameter int NUM_FLAGS = fpsr_pkg::NUM_FLAGS,
    parameter int RM_W      = fpsr_pkg::RM_W,
    localparam int ST_LSB    = RM_W,
    localparam int EN_LSB    = RM_W + NUM_FLAGS,
    localparam int REG_W     = RM_W + 2 * NUM_FLAGS,
    localparam int NUM_MODES = 1 << RM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_end,
    input  logic [NUM_FLAGS-1:0] raw_flags,
    input  logic                 sw_wr_en,
    input  logic [REG_W-1:0]     sw_wr_data,
    output logic [REG_W-1:0]     sw_rd_data,
    output logic [NUM_MODES-1:0] rnd_onehot,
    output logic                 trap_pulse,
    output logic [NUM_FLAGS-1:0] trap_cause
);
    logic [RM_W-1:0]      mode_q;
    logic [NUM_FLAGS-1:0] pending;
    logic [NUM_FLAGS-1:0] sticky;
    logic [NUM_FLAGS-1:0] enable;

    // Rounding-mode field: reset to nearest-even, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RM_W'(fpsr_pkg::RM_NEAREST_EVEN);
        end else if (sw_wr_en) begin
            mode_q <= sw_wr_data[RM_W-1:0];
        end
    end

    fpsr_rnd_decode #(.RM_W(RM_W)) u_decode (
        .mode   (mode_q),
        .onehot (rnd_onehot)
    );

    fpsr_flag_acc #(.NUM_FLAGS(NUM_FLAGS)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_end    (op_end),
        .raw_flags (raw_flags),
        .pending   (pending)
    );

    fpsr_sticky_merge #(.NUM_FLAGS(NUM_FLAGS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_end     (op_end),
        .pending    (pending),
        .sw_wr_en   (sw_wr_en),
        .sw_sticky  (sw_wr_data[ST_LSB +: NUM_FLAGS]),
        .sw_enable  (sw_wr_data[EN_LSB +: NUM_FLAGS]),
        .sticky     (sticky),
        .enable     (enable),
        .trap_pulse (trap_pulse),
        .trap_cause (trap_cause)
    );

    // Pack the register word read back by software.
    always_comb begin
        sw_rd_data                        = '0;
        sw_rd_data[RM_W-1:0]              = mode_q;
        sw_rd_data[ST_LSB +: NUM_FLAGS]   = sticky;
        sw_rd_data[EN_LSB +: NUM_FLAGS]   = enable;
    end
endmodule

// File: rtl/fpsr_ctrl_chk.sv
// Module: fpsr_ctrl_chk
// Port-level property checker for fpsr_ctrl, attached with bind.
// Assumes: the register layout of fpsr_ctrl (mode, sticky, enables from LSB).
module fpsr_ctrl_chk #(
    parameter int NUM_FLAGS = 5,
    parameter int RM_W      = 2,
    localparam int ST_LSB    = RM_W,
    localparam int EN_LSB    = RM_W + NUM_FLAGS,
    localparam int REG_W     = RM_W + 2 * NUM_FLAGS,
    localparam int NUM_MODES = 1 << RM_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_end,
    input logic                 sw_wr_en,
    input logic [REG_W-1:0]     sw_wr_data,
    input logic [REG_W-1:0]     sw_rd_data,
    input logic [NUM_MODES-1:0] rnd_onehot,
    input logic                 trap_pulse,
    input logic [NUM_FLAGS-1:0] trap_cause
);
    logic [NUM_FLAGS-1:0] st_v;
    logic [NUM_FLAGS-1:0] en_v;
    assign st_v = sw_rd_data[ST_LSB +: NUM_FLAGS];
    assign en_v = sw_rd_data[EN_LSB +: NUM_FLAGS];

    p_onehot_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rnd_onehot) == 1);

    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_end && !sw_wr_en) |=> $stable(st_v));

    p_sticky_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_end && !sw_wr_en) |=> ((st_v & $past(st_v)) == $past(st_v)));

    p_trap_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ($past(op_end) && !$past(sw_wr_en)));

    p_no_retrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ((trap_cause & $past(st_v)) == '0));

    p_cause_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ((trap_cause & ~$past(en_v)) == '0));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (sw_rd_data == $past(sw_wr_data) && !trap_pulse));
endmodule

bind fpsr_ctrl fpsr_ctrl_chk #(.NUM_FLAGS(NUM_FLAGS), .RM_W(RM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_end     (op_end),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .sw_rd_data (sw_rd_data),
    .rnd_onehot (rnd_onehot),
    .trap_pulse (trap_pulse),
    .trap_cause (trap_cause)
);

// File: tb/fpsr_ctrl_bench.sv
// Bench for fpsr_ctrl: a table of one-cycle stimulus vectors with expected
// outputs after that cycle's edge, then directed reset checks.
module fpsr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 18;

    typedef struct packed {
        logic        wr;
        logic [11:0] wdata;
        logic        st;
        logic        en;
        logic [4:0]  raw;
        logic [11:0] exp_rd;
        logic [3:0]  exp_oh;
        logic        exp_trap;
        logic [4:0]  exp_cause;
        logic [3:0]  req;
    } vec_t;

    // Flag bits: 0 inexact, 1 divzero, 2 invalid, 3 overflow, 4 underflow.
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 12'h301, 1'b0, 1'b0, 5'h00, 12'h301, 4'h2, 1'b0, 5'h00, 4'd2},  // R2 R10 mode 1, enable divzero+invalid
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'h00, 12'h301, 4'h2, 1'b0, 5'h00, 4'd3},  // R3 start
        '{1'b0, 12'h000, 1'b0, 1'b0, 5'h04, 12'h301, 4'h2, 1'b0, 5'h00, 4'd11}, // R11 invalid mid-op
        '{1'b0, 12'h000, 1'b0, 1'b1, 5'h01, 12'h315, 4'h2, 1'b1, 5'h04, 4'd6},  // R6 R11 end + inexact
        '{1'b0, 12'h000, 1'b0, 1'b0, 5'h00, 12'h315, 4'h2, 1'b0, 5'h00, 4'd6},  // R6 one cycle only
        '{1'b0, 12'h000, 1'b1, 1'b1, 5'h04, 12'h315, 4'h2, 1'b0, 5'h00, 4'd7},  // R7 invalid already sticky
        '{1'b0, 12'h000, 1'b0, 1'b0, 5'h08, 12'h315, 4'h2, 1'b0, 5'h00, 4'd3},  // R3 stale overflow
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'h00, 12'h315, 4'h2, 1'b0, 5'h00, 4'd3},  // R3 start discards it
        '{1'b0, 12'h000, 1'b0, 1'b1, 5'h00, 12'h315, 4'h2, 1'b0, 5'h00, 4'd4},  // R4 empty end
        '{1'b0, 12'h000, 1'b1, 1'b0, 5'h00, 12'h315, 4'h2, 1'b0, 5'h00, 4'd5},  // R5 start
        '{1'b0, 12'h000, 1'b0, 1'b1, 5'h02, 12'h31D, 4'h2, 1'b1, 5'h02, 4'd5},  // R5 divzero added
        '{1'b0, 12'h000, 1'b1, 1'b1, 5'h10, 12'h35D, 4'h2, 1'b0, 5'h00, 4'd8},  // R8 underflow disabled
        '{1'b1, 12'hF83, 1'b1, 1'b1, 5'h08, 12'hF83, 4'h8, 1'b0, 5'h00, 4'd9},  // R9 write beats op end
        '{1'b1, 12'hFFF, 1'b0, 1'b0, 5'h00, 12'hFFF, 4'h8, 1'b0, 5'h00, 4'd10}, // R10 all fields set
        '{1'b0, 12'h000, 1'b1, 1'b1, 5'h1F, 12'hFFF, 4'h8, 1'b0, 5'h00, 4'd7},  // R7 all sticky, no trap
        '{1'b1, 12'hF82, 1'b0, 1'b0, 5'h00, 12'hF82, 4'h4, 1'b0, 5'h00, 4'd2},  // R2 mode 2
        '{1'b0, 12'h000, 1'b1, 1'b1, 5'h08, 12'hFA2, 4'h4, 1'b1, 5'h08, 4'd6},  // R6 overflow trap
        '{1'b0, 12'h000, 1'b0, 1'b0, 5'h00, 12'hFA2, 4'h4, 1'b0, 5'h00, 4'd6}   // R6 pulse ends
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_start;
    logic        op_end;
    logic [4:0]  raw_flags;
    logic        sw_wr_en;
    logic [11:0] sw_wr_data;
    logic [11:0] sw_rd_data;
    logic [3:0]  rnd_onehot;
    logic        trap_pulse;
    logic [4:0]  trap_cause;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpsr_ctrl u_fpsr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_end     (op_end),
        .raw_flags  (raw_flags),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .sw_rd_data (sw_rd_data),
        .rnd_onehot (rnd_onehot),
        .trap_pulse (trap_pulse),
        .trap_cause (trap_cause)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [11:0] rd, input logic [3:0] oh,
                             input logic tp, input logic [4:0] tc);
        check(req, "rd_data", 32'(sw_rd_data), 32'(rd));
        check(req, "onehot",  32'(rnd_onehot), 32'(oh));
        check(req, "trap",    32'(trap_pulse), 32'(tp));
        check(req, "cause",   32'(trap_cause), 32'(tc));
    endtask

    task automatic drive_idle();
        op_start   = 1'b0;
        op_end     = 1'b0;
        raw_flags  = '0;
        sw_wr_en   = 1'b0;
        sw_wr_data = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: state after reset
        check_all("R1", 12'h000, 4'h1, 1'b0, 5'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            sw_wr_en   = VECS[i].wr;
            sw_wr_data = VECS[i].wdata;
            op_start   = VECS[i].st;
            op_end     = VECS[i].en;
            raw_flags  = VECS[i].raw;
            @(negedge clk);
            check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].exp_rd, VECS[i].exp_oh, VECS[i].exp_trap, VECS[i].exp_cause);
        end

        // R1: reset overrides an op_end carrying every flag
        op_start  = 1'b1;
        op_end    = 1'b1;
        raw_flags = 5'h1F;
        rst_n     = 1'b0;
        @(negedge clk);
        check_all("R1", 12'h000, 4'h1, 1'b0, 5'h00);
        drive_idle();
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 12'h000, 4'h1, 1'b0, 5'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule